// File: doc/BRIEF.md
# NAND Flash Page-Read Copy Engine

This block copies a region of a raw NAND flash device into on-chip RAM without processor help. A single-cycle start pulse supplies a RAM destination word address, a byte offset into the flash and a byte count. The engine then runs a fixed sequence for each page. It enables the chip and issues the read command under the command latch. It sends a column address and two row-address bytes under the address latch. It waits for the device's ready/busy pin. Finally it strobes one full page of data words off the bus and writes each of them into a RAM write port.

The flash data bus is presented as separate output, output-enable and input vectors, so that the pad ring can merge them. The bus width is a parameter of 8 or 16 bits. The width sets the number of transfers per page and decides whether the byte offset is halved before it is used. The page loop tests the sign of the remaining byte count after it subtracts a page. For this reason the engine always copies at least one page, and it can copy up to one page more than asked. When the copy is complete the engine pulses done for one cycle.

Top module: `nand_page_reader`

## Requirements
- R1: Outside a copy, and from reset, the pins sit at their inactive levels: nand_ce_n=1, nand_cle=0, nand_ale=0, nand_we_n=1, nand_re_n=1, nand_dq_oe=0. Also ram_we=0 and done=0.
- R2: Each page begins with nand_ce_n=0 and nand_cle=1. Value 0x00 is driven on the bus with one single-cycle nand_we_n low pulse, followed by one hold cycle. nand_cle then stays high for SETTLE (default 20) further cycles.
- R3: Next, nand_cle=0 and nand_ale=1. Three write transfers follow, each a nand_we_n low cycle and then a hold cycle, carrying in this order: 0, word offset bits [15:8], and word offset bits [23:16] (low byte of the bus, upper bits 0). nand_ale then stays high for SETTLE cycles and then drops. nand_cle and nand_ale are never high together.
- R4: After nand_ale drops, no read strobe is issued until nand_rb is sampled high. The first nand_re_n low cycle follows the first edge at which nand_rb=1.
- R5: A page has PAGE_BYTES/(BUS_W/8) transfers: 256 at 16 bits and 512 at 8 bits, for the default PAGE_BYTES=512. Each transfer is one nand_re_n low cycle and then one high cycle. The bus is sampled at the end of the high cycle.
- R6: Each sampled word appears on ram_wdata with ram_we=1 in the cycle after the sample. ram_addr starts at the start destination and goes up by one per word, across pages.
- R7: With BUS_W=16 the byte offset is shifted right by one to form the word offset. With BUS_W=8 it is used unchanged.
- R8: After each page the word offset grows by the transfers per page, and the signed remaining count falls by PAGE_BYTES. A further page follows only if the result is zero or positive. The page count is therefore count/512+1 for count >= 0, and 1 for a negative count.
- R9: One cycle after the last page's final cycle, done is high for exactly one cycle with nand_ce_n=1.
- R10: A start pulse while a copy is running has no effect on the running copy. Its destination, offset and count are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a copy |
| dst_addr | input | AW | RAM word address of the first word |
| src_ofs | input | OFS_W | Byte offset into the flash |
| byte_cnt | input | CNT_W | Signed byte count |
| done | output | 1 | One-cycle pulse at copy end |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | BUS_W | Bus value driven toward the flash |
| nand_dq_oe | output | 1 | Bus drive enable |
| nand_dq_i | input | BUS_W | Bus value returned by the flash |
| nand_rb | input | 1 | Ready (1) / busy (0) from the flash |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM write word address |
| ram_wdata | output | BUS_W | RAM write data |

## Verification
A pin-level flash model captures the row bytes from the address writes, holds ready/busy low for a chosen number of cycles after the address latch falls, and returns a word pattern that depends on both the row and the column. A wrong row, a skipped or extra strobe, or a shifted sample therefore shows up as wrong RAM data. The counts tried are 0, 511, 512, 1000 and a negative value, which separate a loop that ends on the sign from loops that end on zero or round up. A non-zero offset shows the halving for the 16-bit width. Busy windows of zero and of many cycles show that reading waits for ready, and a second start sent in the middle of a copy must leave the addresses unchanged.

// File: rtl/nand_seq_pkg.sv
// Shared types for the NAND page-read copy engine.
package nand_seq_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD_DRV,
        S_CMD_LAT,
        S_CMD_WAIT,
        S_ADR_DRV,
        S_ADR_LAT,
        S_ADR_WAIT,
        S_RB_WAIT,
        S_RD_LOW,
        S_RD_HIGH,
        S_PAGE_END,
        S_FINISH
    } seq_state_e;

    localparam logic [7:0] READ_CODE = 8'h00;
endpackage

// File: rtl/nand_settle_timer.sv
// Settle timer: a load pulse starts a window of SETTLE cycles, and
// expired is high on the last cycle of the window.
// Assumes SETTLE >= 1; expired stays high once the count reaches zero.
module nand_settle_timer #(
    parameter int SETTLE = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int TW = $clog2(SETTLE + 1);

    logic [TW-1:0] cnt;

    // Load the window length, or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= TW'(SETTLE - 1);
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/nand_copy_ctx.sv
// Copy context: holds the flash word offset, the RAM destination and the
// signed remaining byte count for one copy.
// Assumes OFS_W >= 24, so that both row-address bytes exist.
module nand_copy_ctx #(
    parameter int BUS_W      = 16,
    parameter int AW         = 16,
    parameter int OFS_W      = 32,
    parameter int CNT_W      = 24,
    parameter int PAGE_BYTES = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [AW-1:0]    dst_in,
    input  logic [OFS_W-1:0] src_in,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             step_word,
    input  logic             step_page,
    output logic [AW-1:0]    dst,
    output logic [7:0]       row_lo,
    output logic [7:0]       row_hi,
    output logic             more
);
    localparam int PAGE_XFERS = PAGE_BYTES / (BUS_W / 8);

    logic [OFS_W-1:0] ofs_init;
    logic [OFS_W-1:0] word_ofs;
    logic [CNT_W-1:0] remain;
    logic [CNT_W:0]   remain_after;

    // Width picks the conversion of a byte offset to a word offset.
    if (BUS_W == 16) begin : g_w16
        assign ofs_init = src_in >> 1;
    end else begin : g_w8
        assign ofs_init = src_in;
    end

    // Remaining count after one more page, one bit wider to keep the sign.
    assign remain_after = {remain[CNT_W-1], remain} - (CNT_W + 1)'(PAGE_BYTES);
    assign more         = ~remain_after[CNT_W];

    // Load on start; advance the destination per word and the offset/count per page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst      <= '0;
            word_ofs <= '0;
            remain   <= '0;
        end else if (load) begin
            dst      <= dst_in;
            word_ofs <= ofs_init;
            remain   <= cnt_in;
        end else begin
            if (step_word) dst <= dst + 1'b1;
            if (step_page) begin
                word_ofs <= word_ofs + OFS_W'(PAGE_XFERS);
                remain   <= remain_after[CNT_W-1:0];
            end
        end
    end

    assign row_lo = word_ofs[15:8];
    assign row_hi = word_ofs[23:16];
endmodule

// File: rtl/nand_page_reader.sv
// NAND page-read copy engine. For each page it runs the read command,
// the column/row address writes, a settle time, a wait for ready, and
// one page of read strobes whose data go to a RAM write port.
// Assumes BUS_W is 8 or 16 and that the pad ring merges dq_o/dq_oe/dq_i.
module nand_page_reader #(
    parameter int BUS_W      = 16,
    parameter int AW         = 16,
    parameter int OFS_W      = 32,
    parameter int CNT_W      = 24,
    parameter int PAGE_BYTES = 512,
    parameter int SETTLE     = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    dst_addr,
    input  logic [OFS_W-1:0] src_ofs,
    input  logic [CNT_W-1:0] byte_cnt,
    output logic             done,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [BUS_W-1:0] nand_dq_o,
    output logic             nand_dq_oe,
    input  logic [BUS_W-1:0] nand_dq_i,
    input  logic             nand_rb,
    output logic             ram_we,
    output logic [AW-1:0]    ram_addr,
    output logic [BUS_W-1:0] ram_wdata
);
    import nand_seq_pkg::*;

    localparam int PAGE_XFERS = PAGE_BYTES / (BUS_W / 8);
    localparam int XW         = $clog2(PAGE_XFERS);

    seq_state_e   state, state_n;
    logic [1:0]   adr_idx;
    logic [XW-1:0] xfer;
    logic         timer_load, timer_done;
    logic         ctx_load, capture, step_page, more;
    logic [AW-1:0] dst;
    logic [7:0]   row_lo, row_hi;
    logic [7:0]   bus_byte;

    nand_settle_timer #(.SETTLE(SETTLE)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (timer_load),
        .expired (timer_done)
    );

    nand_copy_ctx #(
        .BUS_W(BUS_W), .AW(AW), .OFS_W(OFS_W), .CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES)
    ) u_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ctx_load),
        .dst_in    (dst_addr),
        .src_in    (src_ofs),
        .cnt_in    (byte_cnt),
        .step_word (capture),
        .step_page (step_page),
        .dst       (dst),
        .row_lo    (row_lo),
        .row_hi    (row_hi),
        .more      (more)
    );

    // Next-state and step controls for the per-page sequence.
    always_comb begin
        state_n    = state;
        timer_load = 1'b0;
        ctx_load   = 1'b0;
        capture    = 1'b0;
        step_page  = 1'b0;
        unique case (state)
            S_IDLE:     if (start) begin ctx_load = 1'b1; state_n = S_CMD_DRV; end
            S_CMD_DRV:  state_n = S_CMD_LAT;
            S_CMD_LAT:  begin timer_load = 1'b1; state_n = S_CMD_WAIT; end
            S_CMD_WAIT: if (timer_done) state_n = S_ADR_DRV;
            S_ADR_DRV:  state_n = S_ADR_LAT;
            S_ADR_LAT:  if (adr_idx == 2'd2) begin
                            timer_load = 1'b1;
                            state_n    = S_ADR_WAIT;
                        end else begin
                            state_n = S_ADR_DRV;
                        end
            S_ADR_WAIT: if (timer_done) state_n = S_RB_WAIT;
            S_RB_WAIT:  if (nand_rb) state_n = S_RD_LOW;
            S_RD_LOW:   state_n = S_RD_HIGH;
            S_RD_HIGH:  begin
                            capture = 1'b1;
                            state_n = (xfer == XW'(PAGE_XFERS - 1)) ? S_PAGE_END : S_RD_LOW;
                        end
            S_PAGE_END: begin step_page = 1'b1; state_n = more ? S_CMD_DRV : S_FINISH; end
            S_FINISH:   state_n = S_IDLE;
            default:    state_n = S_IDLE;
        endcase
    end

    // State, address-write index, transfer count and RAM write register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            adr_idx   <= '0;
            xfer      <= '0;
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else begin
            state  <= state_n;
            ram_we <= capture;
            if (state == S_CMD_WAIT)                         adr_idx <= '0;
            else if (state == S_ADR_LAT && adr_idx != 2'd2)  adr_idx <= adr_idx + 1'b1;
            if (state == S_RB_WAIT)                          xfer <= '0;
            else if (state == S_RD_HIGH)                     xfer <= xfer + 1'b1;
            if (capture) begin
                ram_addr  <= dst;
                ram_wdata <= nand_dq_i;
            end
        end
    end

    // Byte placed on the bus during the address writes.
    always_comb begin
        unique case (adr_idx)
            2'd1:    bus_byte = row_lo;
            2'd2:    bus_byte = row_hi;
            default: bus_byte = 8'h00;
        endcase
    end

    // Pin levels decoded from the sequencer state.
    always_comb begin
        nand_ce_n  = (state == S_IDLE) || (state == S_FINISH);
        nand_cle   = (state == S_CMD_DRV) || (state == S_CMD_LAT) || (state == S_CMD_WAIT);
        nand_ale   = (state == S_ADR_DRV) || (state == S_ADR_LAT) || (state == S_ADR_WAIT);
        nand_we_n  = !((state == S_CMD_DRV) || (state == S_ADR_DRV));
        nand_re_n  = (state != S_RD_LOW);
        nand_dq_oe = (state == S_CMD_DRV) || (state == S_CMD_LAT) ||
                     (state == S_ADR_DRV) || (state == S_ADR_LAT);
        nand_dq_o  = '0;
        if (nand_cle) nand_dq_o[7:0] = READ_CODE;
        else          nand_dq_o[7:0] = bus_byte;
        done       = (state == S_FINISH);
    end
endmodule

// File: rtl/nand_page_reader_chk.sv
// Protocol checker for the NAND page-read copy engine, bound to its top.
module nand_page_reader_chk (
    input logic clk,
    input logic rst_n,
    input logic done,
    input logic nand_ce_n,
    input logic nand_cle,
    input logic nand_ale,
    input logic nand_we_n,
    input logic nand_re_n,
    input logic nand_dq_oe,
    input logic nand_rb,
    input logic ram_we
);
    // R1: with the chip deselected every strobe and latch is inactive.
    p_idle_levels_r1: assert property (@(posedge clk) disable iff (!rst_n)
        nand_ce_n |-> (!nand_cle && !nand_ale && nand_we_n && nand_re_n && !nand_dq_oe));

    // R2: a write strobe only happens while the bus is driven.
    p_we_driven_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> nand_dq_oe);

    // R3: the two latch enables are never high together.
    p_one_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R4: a read strobe follows a ready sample.
    p_read_when_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_re_n) |-> $past(nand_rb));

    // R5: the read strobe is low for a single cycle.
    p_strobe_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |=> nand_re_n);

    // R6: a RAM write comes two cycles after a read strobe.
    p_ram_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(!nand_re_n, 2));

    // R9: done is a single-cycle pulse with the chip deselected.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> nand_ce_n ##1 !done);
endmodule

bind nand_page_reader nand_page_reader_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .nand_ce_n  (nand_ce_n),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_dq_oe (nand_dq_oe),
    .nand_rb    (nand_rb),
    .ram_we     (ram_we)
);

// File: tb/tb_nand_page_reader.sv
module tb_nand_page_reader;
    localparam int BW = 16, AW = 16, OW = 32, CW = 24, PB = 512, ST = 20;
    localparam int PX = PB / (BW / 8);

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [AW-1:0] dst_addr = '0;
    logic [OW-1:0] src_ofs = '0;
    logic [CW-1:0] byte_cnt = '0;
    logic done, ce_n, cle, ale, we_n, re_n, dq_oe, ram_we, rb;
    logic [BW-1:0] dq_o, dq_i, ram_wdata;
    logic [AW-1:0] ram_addr;

    always #5 clk = ~clk;

    nand_page_reader dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dst_addr(dst_addr),
        .src_ofs(src_ofs), .byte_cnt(byte_cnt), .done(done),
        .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n),
        .nand_re_n(re_n), .nand_dq_o(dq_o), .nand_dq_oe(dq_oe), .nand_dq_i(dq_i),
        .nand_rb(rb), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    int checks = 0, fails = 0;

    function automatic logic [BW-1:0] fdata(input logic [15:0] row, input int k);
        return BW'(row * 37 + k * 5 + 16'h1234);
    endfunction

    // ---------------- flash device model (pin level) ----------------
    logic [15:0] dev_row = '0;
    int dev_col = 0, dev_adr = 0, busy_len = 0, busy_cnt = 0;
    assign rb   = (busy_cnt == 0);
    assign dq_i = fdata(dev_row, dev_col);
    always @(posedge clk) begin
        if (!ce_n && cle && !we_n) begin dev_adr <= 0; dev_col <= 0; end
        if (!ce_n && ale && !we_n) begin
            if (dev_adr == 1) dev_row[7:0]  <= dq_o[7:0];
            if (dev_adr == 2) dev_row[15:8] <= dq_o[7:0];
            dev_adr <= dev_adr + 1;
        end
        if (!ce_n && !re_n) dev_col <= dev_col + 1;
        if (ale) busy_cnt <= busy_len;
        else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    end

    // ---------------- behavioural reference model ----------------
    logic e_ce_n = 1, e_cle = 0, e_ale = 0, e_we_n = 1, e_re_n = 1, e_oe = 0, e_done = 0;
    logic [BW-1:0] e_dq = '0;
    logic e_ram_we = 0, p_we = 0;
    logic [AW-1:0] e_ram_addr = '0, p_addr = '0;
    logic [BW-1:0] e_ram_data = '0, p_data = '0;
    string e_tag = "R1";

    task automatic put(input logic c, cl, al, w, r, o, input logic [7:0] d, input string tg, input logic dn);
        e_ce_n = c; e_cle = cl; e_ale = al; e_we_n = w; e_re_n = r; e_oe = o;
        e_dq = BW'(d); e_tag = tg; e_done = dn;
        e_ram_we = p_we; e_ram_addr = p_addr; e_ram_data = p_data; p_we = 0;
    endtask

    task automatic step(input logic c, cl, al, w, r, o, input logic [7:0] d, input string tg, input logic dn);
        put(c, cl, al, w, r, o, d, tg, dn);
        @(posedge clk);
    endtask

    task automatic model_copy(input logic [AW-1:0] dst0, input logic [OW-1:0] src0, input logic [CW-1:0] cnt0);
        logic [OW-1:0] wofs;
        logic [AW-1:0] dst;
        logic [15:0] row;
        int rem;
        logic rbs;
        wofs = src0 >> 1;                       // R7: byte offset halved at 16 bits
        dst  = dst0;
        rem  = int'($signed(cnt0));
        do begin
            row = wofs[23:8];
            step(0, 1, 0, 0, 1, 1, 8'h00, "R2", 0);          // command write
            step(0, 1, 0, 1, 1, 1, 8'h00, "R2", 0);
            repeat (ST) step(0, 1, 0, 1, 1, 0, 8'h00, "R2", 0);
            step(0, 0, 1, 0, 1, 1, 8'h00, "R3", 0);          // column 0
            step(0, 0, 1, 1, 1, 1, 8'h00, "R3", 0);
            step(0, 0, 1, 0, 1, 1, row[7:0], "R3", 0);       // row low
            step(0, 0, 1, 1, 1, 1, row[7:0], "R3", 0);
            step(0, 0, 1, 0, 1, 1, row[15:8], "R3", 0);      // row high
            step(0, 0, 1, 1, 1, 1, row[15:8], "R3", 0);
            repeat (ST) step(0, 0, 1, 1, 1, 0, 8'h00, "R3", 0);
            do begin                                          // R4: wait for ready
                put(0, 0, 0, 1, 1, 0, 8'h00, "R4", 0);
                @(negedge clk) rbs = rb;
                @(posedge clk);
            end while (!rbs);
            for (int x = 0; x < PX; x++) begin                // R5 transfers
                step(0, 0, 0, 1, 0, 0, 8'h00, "R5", 0);
                step(0, 0, 0, 1, 1, 0, 8'h00, "R5", 0);
                p_we = 1; p_addr = dst; p_data = fdata(row, x + 1); dst = dst + 1'b1;
            end
            step(0, 0, 0, 1, 1, 0, 8'h00, "R8", 0);          // page end
            wofs = wofs + OW'(PX);
            rem  = rem - PB;
        end while (rem >= 0);                                 // R8
        step(1, 0, 0, 1, 1, 0, 8'h00, "R9", 1);              // done pulse
    endtask

    initial begin
        forever begin
            put(1, 0, 0, 1, 1, 0, 8'h00, "R1", 0);
            @(posedge clk);
            if (rst_n && start) model_copy(dst_addr, src_ofs, byte_cnt);   // R10: starts inside ignored
        end
    end

    // ---------------- per-cycle comparison ----------------
    logic cmp_en = 0;
    int pages = 0, words = 0;
    logic cle_d = 0;
    logic [AW-1:0] last_addr = '0;

    always @(negedge clk) begin
        if (cmp_en) begin
            checks++;
            if ({ce_n, cle, ale, we_n, re_n, dq_oe, done} !== {e_ce_n, e_cle, e_ale, e_we_n, e_re_n, e_oe, e_done}
                || (e_oe && dq_o !== e_dq)) begin
                fails++;
                $display("FAIL %s pins t=%0t act ce_n%b cle%b ale%b we_n%b re_n%b oe%b done%b dq%h exp %b%b%b%b%b%b%b dq%h",
                         e_tag, $time, ce_n, cle, ale, we_n, re_n, dq_oe, done, dq_o,
                         e_ce_n, e_cle, e_ale, e_we_n, e_re_n, e_oe, e_done, e_dq);
            end
            checks++;
            if (ram_we !== e_ram_we || (e_ram_we && (ram_addr !== e_ram_addr || ram_wdata !== e_ram_data))) begin
                fails++;
                $display("FAIL R6 ram t=%0t act we%b a%h d%h exp we%b a%h d%h",
                         $time, ram_we, ram_addr, ram_wdata, e_ram_we, e_ram_addr, e_ram_data);
            end
        end
        if (cle && !cle_d) pages++;
        cle_d = cle;
        if (ram_we) begin words++; last_addr = ram_addr; end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic copy(input logic [AW-1:0] d, input logic [OW-1:0] s, input int cnt, input int busy, input logic poke);
        int exp_pages;
        busy_len = busy;
        pages = 0; words = 0;
        @(negedge clk);
        start = 1; dst_addr = d; src_ofs = s; byte_cnt = CW'(cnt);
        @(negedge clk);
        start = 0;
        if (poke) begin                                   // R10: start during a copy
            repeat (100) @(negedge clk);
            start = 1; dst_addr = d + 16'h4000; src_ofs = 32'h80000; byte_cnt = CW'(5000);
            @(negedge clk);
            start = 0;
        end
        while (!done) @(negedge clk);
        exp_pages = (cnt < 0) ? 1 : cnt / PB + 1;
        check("R8 pages", pages, exp_pages);
        check("R5 words", words, exp_pages * PX);
        check("R6 last addr", int'(last_addr), int'(AW'(d + AW'(exp_pages * PX - 1))));
        check("R7 row", int'(dev_row), int'(16'(((s >> 1) + OW'((exp_pages - 1) * PX)) >> 8)));
        @(negedge clk);
        check("R1 idle after", int'({ce_n, cle, ale, re_n, done}), int'(5'b10010));
        if (poke) check("R10 no restart", int'(ce_n), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset pins", int'({ce_n, cle, ale, we_n, re_n, dq_oe, done, ram_we}), int'(8'b10011000));
        rst_n = 1;
        cmp_en = 1;
        repeat (3) @(negedge clk);
        copy(16'h0100, 32'h0,      0,    5, 0);   // single page, short busy
        copy(16'h0800, 32'h24600,  512,  0, 0);   // R7 offset, exact multiple -> 2 pages
        copy(16'h1000, 32'h1000,   1000, 30, 1);  // long busy, R10 poke
        copy(16'h2000, 32'h200,    511,  3, 0);   // just under a page
        copy(16'h3000, 32'h0,      -4,   1, 0);   // negative count -> 1 page
        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule